// File: doc/BRIEF.md
# Iterative carry-xor signed adder/subtractor

This block adds or subtracts two two's-complement integers without a carry chain. Two registers of equal width hold a carry term and a partial-sum term. On every clock cycle in which the carry term is non-zero, the pair is replaced in one parallel step. The new carry term is the bitwise AND of the two, moved up one bit position. The new partial sum is their bitwise XOR. When the carry term reads all zeros, the partial-sum register holds the exact signed result.

Operands carry `MAG_BITS` magnitude bits plus a sign bit. Inside the block they are widened to `MAG_BITS+2` bits by repeating the sign bit, which gives two sign copies in total. Bits pushed out of the top of the carry register are dropped. Because of this modular width, operand pairs that would never settle in unbounded arithmetic still reach a zero carry. The answer is therefore ready after a number of cycles that depends on the data, not after a fixed latency.

The operand interface is valid/ready. An operand pair is taken on a clock edge where `op_valid` and `op_ready` are both high. `op_ready` falls for the whole computation, and anything presented on the operand pins during that time is ignored. The caller must hold the operands and `sub_sel` steady while `op_valid` is high and `op_ready` is low. The output side has no back-pressure. `done` is a single-cycle notice, and the result pins hold their value until the next operand pair is taken.

Top module: `cvx_addsub`

## Requirements
- R1: While reset is asserted, and after it is released with no operands offered, `op_ready` is 1 and `done`, `fail`, `iter_cnt` and `sum` are all 0.
- R2: An operand pair is accepted only on an edge where `op_valid` and `op_ready` are both 1. `op_ready` is 0 from the next cycle until `done` rises. Operands offered while `op_ready` is 0 change nothing, and each accepted pair produces exactly one `done`.
- R3: With `sub_sel` = 0, `sum` at `done` equals `op_a + op_b` as a `MAG_BITS+2`-bit two's-complement value.
- R4: With `sub_sel` = 1, `sum` at `done` equals `op_a - op_b`, and this includes subtracting the most negative operand. The block does this by loading the negated, sign-extended `op_b` into the partial-sum register.
- R5: On load, the carry register takes sign-extended `op_a` and the partial-sum register takes the selected `op_b` term. Each step sets carry = (carry AND sum) shifted left by one with a 0 entering bit 0, and sum = carry XOR sum. `iter_cnt` at `done` is the number of steps taken until the carry register was zero. While busy, `iter_cnt` rises by one per step.
- R6: If `op_a` is 0, `done` is reported with `iter_cnt` = 0, and `done` appears two edges after the accepting edge.
- R7: Adding a negative `op_a` to `op_b` = |`op_a`| - 1 finishes after exactly one step with `sum` = -1.
- R8: `done` is high for one cycle only. After it, `sum`, `sum_neg`, `sum_mag` and `iter_cnt` stay unchanged until the next pair is accepted.
- R9: `sum_neg` equals the MSB of `sum`. `sum_mag` equals `sum` when `sum_neg` is 0, and the two's complement of `sum` when it is 1. `sum_mag` is read as an unsigned `MAG_BITS+2`-bit value.
- R10: Every operation finishes within `MAG_BITS+2` steps, so `fail` is never raised. `fail` is a guard that would mark a run still unfinished after that many steps.
- R11: `done` rises exactly `iter_cnt + 1` cycles after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operand pair offered |
| op_ready | output | 1 | Block idle and able to take operands |
| op_a | input | MAG_BITS+1 | First operand, two's complement; loaded into the carry register |
| op_b | input | MAG_BITS+1 | Second operand, two's complement |
| sub_sel | input | 1 | 0 adds, 1 subtracts `op_b` from `op_a` |
| done | output | 1 | One-cycle pulse when the result is ready |
| fail | output | 1 | Step limit reached without a zero carry |
| sum | output | MAG_BITS+2 | Signed result (partial-sum register) |
| sum_neg | output | 1 | Result is negative |
| sum_mag | output | MAG_BITS+2 | Unsigned magnitude of the result |
| iter_cnt | output | clog2(MAG_BITS+3) | Steps taken in the current or last operation |

## Verification
The bench builds the block with `MAG_BITS` = 4, which gives 5-bit operands and 6-bit internal registers. At this size every operand pair can be applied in both add and subtract modes. That covers the most negative operands, a result of -32 whose magnitude needs the full unsigned range of `sum_mag`, the pairs that would diverge without the width limit, and the longest step counts the register width allows. On alternate operations, junk operands are offered while the block is busy, to confirm that the interface ignores them.

// File: rtl/cvx_pkg.sv
package cvx_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } cvx_state_e;
endpackage

// File: rtl/cvx_load.sv
// Widens operands by sign repetition and picks the second-register preload.
module cvx_load #(
  parameter int OPND_W = 9,
  parameter int W      = 10
) (
  input  logic [OPND_W-1:0] op_a,
  input  logic [OPND_W-1:0] op_b,
  input  logic              sub_sel,
  output logic [W-1:0]      carry_init,
  output logic [W-1:0]      sum_init
);
  localparam int EXT = W - OPND_W;

  logic [W-1:0] b_wide;

  assign carry_init = {{EXT{op_a[OPND_W-1]}}, op_a};
  assign b_wide     = {{EXT{op_b[OPND_W-1]}}, op_b};

  // negation happens in the wide domain so the most negative operand survives
  assign sum_init = sub_sel ? (~b_wide + W'(1)) : b_wide;
endmodule

// File: rtl/cvx_step.sv
// One parallel AND-shift / XOR step across all bit slices.
module cvx_step #(
  parameter int W = 10
) (
  input  logic [W-1:0] carry_q,
  input  logic [W-1:0] sum_q,
  output logic [W-1:0] carry_d,
  output logic [W-1:0] sum_d,
  output logic         carry_zero
);
  assign carry_d[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_slice
    assign sum_d[i] = carry_q[i] ^ sum_q[i];
    if (i > 0) begin : g_carry
      assign carry_d[i] = carry_q[i-1] & sum_q[i-1];
    end
  end

  assign carry_zero = ~|carry_q;
endmodule

// File: rtl/cvx_ctrl.sv
// Sequencer: load, step until the carry is clear, then pulse done.
module cvx_ctrl
  import cvx_pkg::*;
#(
  parameter int W     = 10,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             carry_zero,
  output logic             busy,
  output logic             step_en,
  output logic             done,
  output logic             fail,
  output logic [CNT_W-1:0] iter_cnt
);
  cvx_state_e       state_q;
  logic [CNT_W-1:0] iter_q;
  logic             at_limit;

  assign at_limit = (iter_q == CNT_W'(W));
  assign busy     = (state_q == ST_RUN);
  assign step_en  = busy && !carry_zero && !at_limit;
  assign iter_cnt = iter_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      iter_q  <= '0;
      done    <= 1'b0;
      fail    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q <= ST_RUN;
            iter_q  <= '0;
            fail    <= 1'b0;
          end
        end
        ST_RUN: begin
          if (carry_zero) begin
            state_q <= ST_IDLE;
            done    <= 1'b1;
          end else if (at_limit) begin
            state_q <= ST_IDLE;
            fail    <= 1'b1;
          end else begin
            iter_q <= iter_q + CNT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cvx_result.sv
// Sign flag and unsigned magnitude of the partial-sum register.
module cvx_result #(
  parameter int W = 10
) (
  input  logic [W-1:0] sum_q,
  output logic         is_neg,
  output logic [W-1:0] magnitude
);
  assign is_neg    = sum_q[W-1];
  assign magnitude = is_neg ? (~sum_q + W'(1)) : sum_q;
endmodule

// File: rtl/cvx_addsub.sv
module cvx_addsub #(
  parameter  int MAG_BITS = 8,
  localparam int OPND_W   = MAG_BITS + 1,
  localparam int W        = MAG_BITS + 2,
  localparam int CNT_W    = $clog2(W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [OPND_W-1:0] op_a,
  input  logic [OPND_W-1:0] op_b,
  input  logic              sub_sel,
  output logic              done,
  output logic              fail,
  output logic [W-1:0]      sum,
  output logic              sum_neg,
  output logic [W-1:0]      sum_mag,
  output logic [CNT_W-1:0]  iter_cnt
);
  logic [W-1:0] carry_q, sum_q;
  logic [W-1:0] carry_init, sum_init;
  logic [W-1:0] carry_d, sum_d;
  logic         carry_zero, busy, step_en, accept;

  assign op_ready = !busy;
  assign accept   = op_valid && op_ready;

  cvx_load #(.OPND_W(OPND_W), .W(W)) u_load (
    .op_a       (op_a),
    .op_b       (op_b),
    .sub_sel    (sub_sel),
    .carry_init (carry_init),
    .sum_init   (sum_init)
  );

  cvx_step #(.W(W)) u_step (
    .carry_q    (carry_q),
    .sum_q      (sum_q),
    .carry_d    (carry_d),
    .sum_d      (sum_d),
    .carry_zero (carry_zero)
  );

  cvx_ctrl #(.W(W), .CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .carry_zero (carry_zero),
    .busy       (busy),
    .step_en    (step_en),
    .done       (done),
    .fail       (fail),
    .iter_cnt   (iter_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      carry_q <= '0;
      sum_q   <= '0;
    end else if (accept) begin
      carry_q <= carry_init;
      sum_q   <= sum_init;
    end else if (step_en) begin
      carry_q <= carry_d;
      sum_q   <= sum_d;
    end
  end

  assign sum = sum_q;

  cvx_result #(.W(W)) u_result (
    .sum_q     (sum_q),
    .is_neg    (sum_neg),
    .magnitude (sum_mag)
  );
endmodule

// File: rtl/cvx_addsub_chk.sv
module cvx_addsub_chk #(
  parameter int OPND_W = 9,
  parameter int W      = 10,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic              op_ready,
  input logic [OPND_W-1:0] op_a,
  input logic              done,
  input logic              fail,
  input logic [W-1:0]      sum,
  input logic              sum_neg,
  input logic [W-1:0]      sum_mag,
  input logic [CNT_W-1:0]  iter_cnt
);
  p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_ready |=> !op_ready);

  p_step_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !op_ready |=> (done && $stable(iter_cnt)) || (iter_cnt == CNT_W'($past(iter_cnt) + 1'b1)));

  p_zero_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_ready && (op_a == '0) |-> ##2 (done && iter_cnt == '0));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op_ready && !op_valid |=> $stable(sum) && $stable(iter_cnt));

  p_mag_pos_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done && !sum_neg |-> (sum_mag == sum) && !sum[W-1]);

  p_mag_neg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done && sum_neg |-> (W'(sum_mag + sum) == '0) && sum[W-1]);

  p_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !fail && (iter_cnt <= CNT_W'(W)));
endmodule

bind cvx_addsub cvx_addsub_chk #(.OPND_W(OPND_W), .W(W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_valid (op_valid),
  .op_ready (op_ready),
  .op_a     (op_a),
  .done     (done),
  .fail     (fail),
  .sum      (sum),
  .sum_neg  (sum_neg),
  .sum_mag  (sum_mag),
  .iter_cnt (iter_cnt)
);

// File: tb/cvx_addsub_tb.sv
module cvx_addsub_tb;
  localparam int MAG_BITS = 4;
  localparam int OPND_W   = MAG_BITS + 1;
  localparam int W        = MAG_BITS + 2;
  localparam int CNT_W    = $clog2(W + 1);
  localparam int OP_MIN   = -(1 << MAG_BITS);
  localparam int OP_MAX   = (1 << MAG_BITS) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              op_valid = 1'b0;
  logic              op_ready;
  logic [OPND_W-1:0] op_a = '0;
  logic [OPND_W-1:0] op_b = '0;
  logic              sub_sel = 1'b0;
  logic              done, fail, sum_neg;
  logic [W-1:0]      sum, sum_mag;
  logic [CNT_W-1:0]  iter_cnt;

  always #5 clk = ~clk;

  cvx_addsub #(.MAG_BITS(MAG_BITS)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_a(op_a), .op_b(op_b), .sub_sel(sub_sel), .done(done), .fail(fail),
    .sum(sum), .sum_neg(sum_neg), .sum_mag(sum_mag), .iter_cnt(iter_cnt)
  );

  typedef struct {
    logic [W-1:0] exp_sum;
    int           exp_iter;
    int           acc;
    string        tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit prev_done = 1'b0;
  bit reported = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
  endtask

  // reference step count from the R5 rule
  function automatic int ref_steps(logic [W-1:0] c, logic [W-1:0] s);
    int k = 0;
    while (c != '0 && k < 64) begin
      logic [W-1:0] nc, ns;
      nc = (c & s) << 1;
      ns = c ^ s;
      c = nc;
      s = ns;
      k++;
    end
    return k;
  endfunction

  function automatic logic [W-1:0] wide(int v);
    return W'(v);
  endfunction

  // driver: offers one pair, pushes the expectation, optionally offers junk while busy
  task automatic send(input int a, input int b, input bit sub, input bit junk,
                      input string tag, input int force_iter);
    item_t it;
    logic [W-1:0] s0;
    @(negedge clk);
    while (!op_ready) @(negedge clk);
    op_valid = 1'b1;
    op_a = OPND_W'(a);
    op_b = OPND_W'(b);
    sub_sel = sub;
    @(negedge clk);
    s0 = sub ? wide(-b) : wide(b);
    it.exp_sum  = sub ? wide(a - b) : wide(a + b);
    it.exp_iter = (force_iter >= 0) ? force_iter : ref_steps(wide(a), s0);
    it.acc      = cyc;
    it.tag      = tag;
    q.push_back(it);
    if (junk) begin
      op_a = ~op_a;
      op_b = op_b + OPND_W'(3);
      sub_sel = ~sub;
      @(negedge clk);
    end
    op_valid = 1'b0;
  endtask

  // monitor: pops and compares as results appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (fail) chk(1'b0, "R10", "fail flag", 1, 0);
      if (done && prev_done) chk(1'b0, "R8", "done longer than one cycle", 2, 1);
      if (done && !prev_done) begin
        if (q.size() == 0) begin
          chk(1'b0, "R2", "done without an accepted pair", 1, 0);
        end else begin
          item_t it;
          logic [W-1:0] em;
          it = q.pop_front();
          em = it.exp_sum[W-1] ? (~it.exp_sum + W'(1)) : it.exp_sum;
          chk(sum == it.exp_sum, it.tag, "sum", int'($signed(sum)), int'($signed(it.exp_sum)));
          chk(sum_neg == it.exp_sum[W-1], "R9", "sum_neg", int'(sum_neg), int'(it.exp_sum[W-1]));
          chk(sum_mag == em, "R9", "sum_mag", int'(sum_mag), int'(em));
          chk(int'(iter_cnt) == it.exp_iter, "R5", "iter_cnt", int'(iter_cnt), it.exp_iter);
          chk(int'(iter_cnt) <= W, "R10", "iter_cnt bound", int'(iter_cnt), W);
          chk(cyc - it.acc == it.exp_iter + 1, "R11", "latency", cyc - it.acc, it.exp_iter + 1);
        end
      end
      prev_done = done;
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      failures++;
      $display("FAIL R11 watchdog actual=%0d expected=%0d", cyc, 150000);
      report();
      $finish;
    end
  end

  initial begin
    logic [W-1:0] hold_sum;
    logic [CNT_W-1:0] hold_it;
    repeat (3) @(negedge clk);
    chk(op_ready == 1'b1, "R1", "op_ready in reset", int'(op_ready), 1);
    chk(done == 1'b0 && fail == 1'b0, "R1", "done/fail in reset", int'(done | fail), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(iter_cnt == '0, "R1", "iter_cnt after reset", int'(iter_cnt), 0);
    chk(sum == '0, "R1", "sum after reset", int'(sum), 0);
    chk(op_ready == 1'b1, "R1", "op_ready after reset", int'(op_ready), 1);

    // directed corner cases
    send(0, 7, 0, 0, "R6", 0);
    send(0, -5, 1, 1, "R6", 0);
    send(-3, 2, 0, 0, "R7", 1);
    send(-16, 15, 0, 1, "R7", 1);
    send(14, -11, 0, 0, "R3", -1);
    send(2, 2, 1, 0, "R4", -1);
    send(-1, 1, 0, 0, "R3", -1);
    send(-16, -16, 0, 0, "R3", -1);
    send(15, -16, 1, 1, "R4", -1);
    send(-16, 15, 1, 0, "R4", -1);

    // exhaustive sweep, junk offered on alternate operations (R2)
    for (int s = 0; s < 2; s++)
      for (int a = OP_MIN; a <= OP_MAX; a++)
        for (int b = OP_MIN; b <= OP_MAX; b++)
          send(a, b, bit'(s), bit'((a ^ b) & 1), s ? "R4" : "R3", -1);

    // let the last result arrive, then confirm it holds (R8)
    @(negedge clk);
    while (q.size() != 0 || !op_ready) @(negedge clk);
    @(negedge clk);
    hold_sum = sum;
    hold_it = iter_cnt;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(sum == hold_sum, "R8", "sum held", int'(sum), int'(hold_sum));
      chk(iter_cnt == hold_it, "R8", "iter_cnt held", int'(iter_cnt), int'(hold_it));
      chk(done == 1'b0, "R8", "no repeat done", int'(done), 0);
    end
    chk(q.size() == 0, "R2", "pending results", q.size(), 0);
    report();
    $finish;
  end
endmodule